// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Margin Flags

This block is a 64-word by 9-bit first-in first-out buffer. It has a write port in one clock domain and a read port in another. The two clocks may be unrelated, or the same clock may drive both ports. Write and read positions cross between the domains as Gray-coded pointers through two-flop synchronizers.

The block drives four active-low status flags. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. Every flag comes from a possibly stale copy of the other side's pointer, so a flag can release a few cycles late but never asserts late.

A dual-purpose write pin selects one of two write modes, depending on its level during reset. In dual-enable mode a write needs both enables, and both almost margins are fixed at 7. In margin mode the primary enable alone qualifies a write, and the two margins come from input ports that an external loader sets. The read data is registered. It is masked by an active-low output enable, which stands in for a three-state bus.

Top module: `dcfifo_pflag`

## Requirements
- R1: In margin mode, a word is stored on a rising `wclk` edge when `wr_en_n` is 0, whatever the level of `wr_en2_ld`.
- R2: In dual-enable mode, a word is stored only when `wr_en_n` is 0 and `wr_en2_ld` is 1. With `wr_en2_ld` at 0 the store is dropped.
- R3: A word is removed on a rising `rclk` edge only when `rd_en_a_n` and `rd_en_b_n` are both 0. `rd_data` takes the oldest word at that edge and holds it until the next read. Words leave in the order they were written.
- R4: A write offered while `full_n` is 0 is dropped. A read offered while `empty_n` is 0 is dropped, and `rd_data` keeps its value.
- R5: After reset, `empty_n`=0, `ae_n`=0, `full_n`=1, `af_n`=1, `rd_data`=0, and the buffer holds no words.
- R6: Once both clocks have run idle for several cycles with L words stored, `empty_n` is 0 exactly when L=0, and `full_n` is 0 exactly when L=64.
- R7: Once idle, `ae_n` is 0 exactly when L is at most the empty margin. The empty margin is `ae_ofs` in margin mode and 7 in dual-enable mode.
- R8: Once idle, `af_n` is 0 exactly when 64-L is at most the full margin. The full margin is `af_ofs` in margin mode and 7 in dual-enable mode.
- R9: While `oe_n` is 1, `rd_vld` is 0 and `rd_data` is 0. While `oe_n` is 0, `rd_vld` is 1 and `rd_data` shows the registered word.
- R10: The flags are never optimistic. While `empty_n` is 1, at least one word is stored. While `full_n` is 1, fewer than 64 words are stored. While `ae_n` is 1, the count exceeds the empty margin. While `af_n` is 1, the free space exceeds the full margin.
- R11: `wr_en2_ld` is sampled as the mode select (1 = dual-enable, 0 = margin) until each domain's internal reset releases, two clock edges after `rst_n` rises. Later changes on the pin do not change the mode.
- R12: All behaviour above holds when `wclk` and `rclk` are the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| wr_data | input | 9 | Word to store |
| wr_en_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Mode select during reset; in dual-enable mode, second write enable (active high) |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ae_ofs | input | 6 | Empty margin used in margin mode |
| af_ofs | input | 6 | Full margin used in margin mode |
| rd_data | output | 9 | Registered read word, 0 while masked |
| rd_vld | output | 1 | High when the output is driven |
| empty_n | output | 1 | Empty flag, active low, read domain |
| ae_n | output | 1 | Almost-empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| af_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
The main function is tried with three kinds of input pattern.

The first is a one-word-at-a-time walk through all 65 fill levels, up and back down, with the clocks idled between steps. It is run in dual-enable mode and in margin mode with two different margin pairs. This pins each flag's threshold to the exact level and tells a margin off by one from a correct one.

The second is a set of enable patterns that must be ignored: a second write enable held low, a single read enable, writes into a full buffer and reads from an empty one. These separate the mode-dependent write qualification from the plain enables.

The third is continuous streaming with irregular gaps, under unrelated clocks and under one shared clock. It checks ordering through pointer wrap and the never-late property of the flags while both pointers move.

// File: rtl/fifo_cfg_pkg.sv
package fifo_cfg_pkg;
  typedef enum logic {
    WMODE_MARGIN = 1'b0,
    WMODE_DUAL   = 1'b1
  } wr_mode_e;

  localparam int unsigned DEF_MARGIN = 7;
endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= '0;
      q        <= '0;
    end else begin
      stage1_q <= d;
      q        <= stage1_q;
    end
  end
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
  import fifo_cfg_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen_a_n,
  input  logic          wen_b,
  input  logic [AW-1:0] margin_in,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   bin,
  output logic [AW:0]   gray,
  output logic          fire,
  output logic          full_n,
  output logic          afull_n,
  output wr_mode_e      mode
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);
  localparam logic [AW-1:0] DEF_M   = AW'(DEF_MARGIN);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] bin_q, gray_q, bin_nx, gray_nx, rbin_s, lvl_nx, free_nx;
  logic          full_n_q, afull_n_q, full_n_nx, afull_n_nx, want;
  logic [AW-1:0] margin_eff;
  wr_mode_e      mode_q;

  // mode select follows the pin for as long as the domain is in reset
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= wen_b ? WMODE_DUAL : WMODE_MARGIN;
  end

  always_comb begin
    want       = (mode_q == WMODE_DUAL) ? (!wen_a_n && wen_b) : !wen_a_n;
    fire       = want && full_n_q;
    bin_nx     = bin_q + PW'(fire);
    gray_nx    = bin_nx ^ (bin_nx >> 1);
    rbin_s     = g2b(rgray_s);
    lvl_nx     = bin_nx - rbin_s;
    free_nx    = DEPTH_P - lvl_nx;
    margin_eff = (mode_q == WMODE_DUAL) ? DEF_M : margin_in;
    full_n_nx  = (lvl_nx != DEPTH_P);
    afull_n_nx = !(free_nx <= {1'b0, margin_eff});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q     <= '0;
      gray_q    <= '0;
      full_n_q  <= 1'b1;
      afull_n_q <= 1'b1;
    end else begin
      bin_q     <= bin_nx;
      gray_q    <= gray_nx;
      full_n_q  <= full_n_nx;
      afull_n_q <= afull_n_nx;
    end
  end

  assign bin     = bin_q;
  assign gray    = gray_q;
  assign full_n  = full_n_q;
  assign afull_n = afull_n_q;
  assign mode    = mode_q;
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
  import fifo_cfg_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_a_n,
  input  logic          ren_b_n,
  input  logic          mode_pin,
  input  logic [AW-1:0] margin_in,
  input  logic [AW:0]   wgray_s,
  output logic [AW:0]   bin,
  output logic [AW:0]   gray,
  output logic          fire,
  output logic          empty_n,
  output logic          aempty_n,
  output wr_mode_e      mode
);
  localparam int PW = AW + 1;
  localparam logic [AW-1:0] DEF_M = AW'(DEF_MARGIN);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] bin_q, gray_q, bin_nx, gray_nx, wbin_s, lvl_nx;
  logic          empty_n_q, aempty_n_q, empty_n_nx, aempty_n_nx;
  logic [AW-1:0] margin_eff;
  wr_mode_e      mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_pin ? WMODE_DUAL : WMODE_MARGIN;
  end

  always_comb begin
    fire        = !ren_a_n && !ren_b_n && empty_n_q;
    bin_nx      = bin_q + PW'(fire);
    gray_nx     = bin_nx ^ (bin_nx >> 1);
    wbin_s      = g2b(wgray_s);
    lvl_nx      = wbin_s - bin_nx;
    margin_eff  = (mode_q == WMODE_DUAL) ? DEF_M : margin_in;
    empty_n_nx  = (lvl_nx != '0);
    aempty_n_nx = !(lvl_nx <= {1'b0, margin_eff});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q      <= '0;
      gray_q     <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
    end else begin
      bin_q      <= bin_nx;
      gray_q     <= gray_nx;
      empty_n_q  <= empty_n_nx;
      aempty_n_q <= aempty_n_nx;
    end
  end

  assign bin      = bin_q;
  assign gray     = gray_q;
  assign empty_n  = empty_n_q;
  assign aempty_n = aempty_n_q;
  assign mode     = mode_q;
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wclk) begin
    if (we) store_q[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata_q <= '0;
    else if (re)  rdata_q <= store_q[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
  import fifo_cfg_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_en_n,
  input  logic          wr_en2_ld,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          oe_n,
  input  logic [AW-1:0] ae_ofs,
  input  logic [AW-1:0] af_ofs,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld,
  output logic          empty_n,
  output logic          ae_n,
  output logic          full_n,
  output logic          af_n
);
  localparam int PW = AW + 1;

  logic          wrst_n, rrst_n, w_fire, r_fire;
  logic [PW-1:0] w_bin, w_gray, r_bin, r_gray, w_gray_s, r_gray_s;
  logic [DW-1:0] mem_q;
  wr_mode_e      w_mode, r_mode;

  fifo_sync #(.W(1)) wrst_sync_i (.clk(wclk), .arst_n(rst_n), .d(1'b1), .q(wrst_n));
  fifo_sync #(.W(1)) rrst_sync_i (.clk(rclk), .arst_n(rst_n), .d(1'b1), .q(rrst_n));

  fifo_sync #(.W(PW)) w2r_i (.clk(rclk), .arst_n(rrst_n), .d(w_gray), .q(w_gray_s));
  fifo_sync #(.W(PW)) r2w_i (.clk(wclk), .arst_n(wrst_n), .d(r_gray), .q(r_gray_s));

  fifo_wr_side #(.AW(AW)) wr_i (
    .clk(wclk), .rst_n(wrst_n), .wen_a_n(wr_en_n), .wen_b(wr_en2_ld),
    .margin_in(af_ofs), .rgray_s(r_gray_s), .bin(w_bin), .gray(w_gray),
    .fire(w_fire), .full_n(full_n), .afull_n(af_n), .mode(w_mode)
  );

  fifo_rd_side #(.AW(AW)) rd_i (
    .clk(rclk), .rst_n(rrst_n), .ren_a_n(rd_en_a_n), .ren_b_n(rd_en_b_n),
    .mode_pin(wr_en2_ld), .margin_in(ae_ofs), .wgray_s(w_gray_s),
    .bin(r_bin), .gray(r_gray), .fire(r_fire), .empty_n(empty_n),
    .aempty_n(ae_n), .mode(r_mode)
  );

  fifo_mem #(.AW(AW), .DW(DW)) mem_i (
    .wclk(wclk), .we(w_fire), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
    .rclk(rclk), .rrst_n(rrst_n), .re(r_fire), .raddr(r_bin[AW-1:0]),
    .rdata(mem_q)
  );

  assign rd_vld  = !oe_n;
  assign rd_data = oe_n ? '0 : mem_q;
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk
  import fifo_cfg_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          wclk,
  input logic          rclk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          wen_b,
  input logic [AW:0]   w_bin,
  input logic [AW:0]   r_bin,
  input logic          full_n,
  input logic          af_n,
  input logic          empty_n,
  input logic          ae_n,
  input logic [AW-1:0] ae_ofs,
  input logic [AW-1:0] af_ofs,
  input wr_mode_e      w_mode,
  input wr_mode_e      r_mode
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic [PW-1:0] true_lvl, ae_lim, af_lim;
  assign true_lvl = w_bin - r_bin;
  assign ae_lim   = (r_mode == WMODE_DUAL) ? PW'(DEF_MARGIN) : {1'b0, ae_ofs};
  assign af_lim   = (w_mode == WMODE_DUAL) ? PW'(DEF_MARGIN) : {1'b0, af_ofs};

  p_full_blocks_wr_r4: assert property (@(posedge wclk) disable iff (!wrst_n)
    !full_n |=> $stable(w_bin));
  p_empty_blocks_rd_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    !empty_n |=> $stable(r_bin));
  p_no_overflow_r10: assert property (@(posedge wclk) disable iff (!wrst_n)
    true_lvl <= DEPTH_P);
  p_no_underflow_r10: assert property (@(posedge rclk) disable iff (!rrst_n)
    true_lvl <= DEPTH_P);
  p_ae_never_late_r10: assert property (@(posedge rclk) disable iff (!rrst_n)
    ae_n |-> (true_lvl > ae_lim));
  p_af_never_late_r10: assert property (@(posedge wclk) disable iff (!wrst_n)
    af_n |-> ((DEPTH_P - true_lvl) > af_lim));
  p_dual_needs_en2_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    (w_mode == WMODE_DUAL && !wen_b) |=> $stable(w_bin));
  p_mode_held_r11: assert property (@(posedge wclk) disable iff (!wrst_n)
    $stable(w_mode));
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.AW(AW)) chk_i (
  .wclk(wclk), .rclk(rclk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .wen_b(wr_en2_ld), .w_bin(w_bin), .r_bin(r_bin), .full_n(full_n),
  .af_n(af_n), .empty_n(empty_n), .ae_n(ae_n), .ae_ofs(ae_ofs),
  .af_ofs(af_ofs), .w_mode(w_mode), .r_mode(r_mode)
);

// File: tb/dcfifo_pflag_tb_top.sv
module dcfifo_pflag_tb_top;
  localparam int AW = 6;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk_f = 1'b0, tie = 1'b0;
  logic rclk;
  always #5 wclk = ~wclk;
  always #7 rclk_f = ~rclk_f;
  assign rclk = tie ? wclk : rclk_f;

  logic rst_n, wr_en_n, wr_en2_ld, rd_en_a_n, rd_en_b_n, oe_n;
  logic [DW-1:0] wr_data, rd_data;
  logic [AW-1:0] ae_ofs, af_ofs;
  logic rd_vld, empty_n, ae_n, full_n, af_n;

  dcfifo_pflag #(.AW(AW), .DW(DW)) dut_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_en_n(wr_en_n), .wr_en2_ld(wr_en2_ld), .rd_en_a_n(rd_en_a_n),
    .rd_en_b_n(rd_en_b_n), .oe_n(oe_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .rd_data(rd_data), .rd_vld(rd_vld), .empty_n(empty_n), .ae_n(ae_n),
    .full_n(full_n), .af_n(af_n)
  );

  int checks = 0, failures = 0;
  bit done = 0, dual = 0;
  int ae_m = 7, af_m = 7;
  logic [DW-1:0] model_q[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic check_flags(input string tag);
    int lvl;
    logic [3:0] exp;
    lvl = model_q.size();
    exp = {lvl != 0, lvl > ae_m, lvl != DEPTH, (DEPTH - lvl) > af_m};
    chk(tag, {28'd0, empty_n, ae_n, full_n, af_n}, {28'd0, exp});
  endtask

  task automatic do_reset(input bit pin, input int ae, input int af);
    rst_n = 1'b0; wr_en2_ld = pin; wr_en_n = 1'b1; wr_data = '0;
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; oe_n = 1'b0;
    ae_ofs = AW'(ae); af_ofs = AW'(af);
    dual = pin; ae_m = pin ? 7 : ae; af_m = pin ? 7 : af;
    model_q.delete();
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    rst_n = 1'b1;
    settle();
    chk("R5 reset flags", {28'd0, empty_n, ae_n, full_n, af_n}, 32'h3);
    chk("R5 reset data", int'(rd_data), 0);
  endtask

  // in margin mode the second pin toggles with the data to show it is ignored (R1, R11)
  task automatic push(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_data = d; wr_en_n = 1'b0;
    wr_en2_ld = dual ? 1'b1 : d[0];
    @(negedge wclk);
    wr_en_n = 1'b1;
    if (model_q.size() < DEPTH) model_q.push_back(d);
  endtask

  task automatic pop(input string tag);
    logic [DW-1:0] prev, exp;
    @(negedge rclk);
    prev = rd_data; rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
    @(negedge rclk);
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
    exp = (model_q.size() > 0) ? model_q.pop_front() : prev;
    chk(tag, int'(rd_data), int'(exp));
  endtask

  task automatic sweep(input int seed);
    for (int i = 0; i < DEPTH; i++) begin
      push(DW'(i * 37 + seed));
      settle();
      check_flags("R1 R6 R7 R8 fill");
    end
    push(DW'(9'h155));
    settle();
    check_flags("R4 R6 write into full");
    for (int i = 0; i < DEPTH; i++) begin
      pop("R3 drain order");
      settle();
      check_flags("R6 R7 R8 drain");
    end
    pop("R4 read from empty keeps data");
    settle();
    check_flags("R4 R6 after empty read");
  endtask

  task automatic stream(input int n, input string tag);
    fork
      begin
        int sent = 0, cyc = 0;
        while (sent < n) begin
          @(negedge wclk);
          if (full_n && (cyc % 7) != 2) begin
            wr_data = DW'(sent * 53 + 11); wr_en_n = 1'b0;
            wr_en2_ld = dual ? 1'b1 : 1'b0;
            model_q.push_back(wr_data);
            sent++;
          end else begin
            wr_en_n = 1'b1;
          end
          cyc++;
        end
        @(negedge wclk);
        wr_en_n = 1'b1;
      end
      begin
        int got = 0, cyc = 0;
        bit pend = 0;
        while (got < n) begin
          @(negedge rclk);
          if (pend) begin
            chk(tag, int'(rd_data), int'(model_q.pop_front()));
            got++;
          end
          pend = (got < n) && empty_n && (cyc % 5) != 0;
          rd_en_a_n = !pend; rd_en_b_n = !pend;
          cyc++;
        end
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
      end
    join
    settle();
    check_flags("R10 R6 after stream");
  endtask

  initial begin
    logic [DW-1:0] hold;
    // dual-enable mode, unrelated clocks
    do_reset(1'b1, 0, 0);
    @(negedge wclk);
    wr_data = 9'h0AA; wr_en_n = 1'b0; wr_en2_ld = 1'b0;
    repeat (4) @(negedge wclk);
    wr_en_n = 1'b1; wr_en2_ld = 1'b1;
    settle();
    check_flags("R2 second enable low blocks write");
    push(9'h1A5); push(9'h0C3);
    settle();
    @(negedge rclk);
    hold = rd_data; rd_en_a_n = 1'b0; rd_en_b_n = 1'b1;
    repeat (3) @(negedge rclk);
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b0;
    repeat (3) @(negedge rclk);
    rd_en_b_n = 1'b1;
    chk("R3 single read enable ignored", int'(rd_data), int'(hold));
    settle();
    check_flags("R3 level kept after single enable");
    pop("R2 R3 first word");
    pop("R3 second word");
    oe_n = 1'b1; #1;
    chk("R9 masked valid", int'(rd_vld), 0);
    chk("R9 masked data", int'(rd_data), 0);
    oe_n = 1'b0; #1;
    chk("R9 driven valid", int'(rd_vld), 1);
    chk("R9 driven data", int'(rd_data), 'h0C3);
    settle();
    sweep(5);
    stream(200, "R3 R10 dual-enable stream");

    // margin mode, unrelated clocks
    do_reset(1'b0, 3, 10);
    sweep(17);
    stream(200, "R1 R10 margin stream");

    // margin mode, shared clock
    tie = 1'b1;
    do_reset(1'b0, 12, 5);
    sweep(101);
    stream(200, "R12 shared clock stream");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule